// File: doc/BRIEF.md
# RAM-Based Multi-Tap Delay Line

This block is a tapped delay line whose stages live in small memory banks, not in a chain of flip-flops. Each accepted input word enters the first bank. Each later bank receives the word that the bank before it gives up. A single rotating address counter walks all the banks together. A word therefore shows up on tap k exactly (k+1)*M accepted words after it entered. The block suits long filter and alignment delays, where a register chain would cost far more flops than a memory.

The data input and the outputs have no registers of their own. Every output changes only on a rising clock edge, because the address that selects it and the memory behind it are both updated on that edge. A small state machine tracks how full the line is, so that after any clear no stale memory word can reach a tap. It has three states: `ST_CLEAR` (nothing stored since the last clear), `ST_FILL` (partly filled) and `ST_FULL` (every tap holds live data). Its transitions are:

- `ST_CLEAR`→`ST_FILL` on the first accepted word.
- `ST_FILL`→`ST_FULL` on the N*M-th accepted word.
- Any state→`ST_CLEAR` on a synchronous or asynchronous clear.
- `ST_FULL` otherwise holds.

Top module: `tdl_ram_tapline`

## Requirements
- R1: With parameters W (word width), N (tap count) and M (tap spacing), tap k (k = 0 .. N-1) sits on bits [(k+1)*W-1 : k*W] of `taps` and shows the word accepted (k+1)*M accepted words earlier.
- R2: `dout` always equals the most significant W-bit word of `taps`, that is tap N-1.
- R3: Elaboration fails with an error when M is less than 3.
- R4: A word is accepted on a rising edge only when `en` is 1 and `sclr` is 0. When `en` is 0, the edge leaves the outputs unchanged and the value on `din` has no effect.
- R5: While `arst` is 1, all outputs are zero at once, with no clock edge needed. After release, the line starts empty.
- R6: A rising edge with `sclr` at 1 empties the line, whatever the value of `en`. All outputs read zero right after that edge and no word is accepted.
- R7: After a clear, tap k reads zero until (k+1)*M words have been accepted. It never exposes memory contents from before the clear.
- R8: The outputs change only at rising clock edges. A change on `din` between edges does not alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous clear, active high |
| sclr | input | 1 | Synchronous clear, active high, has priority over `en` |
| en | input | 1 | Accept enable for the address counter and memory writes |
| din | input | W | Word shifted in |
| taps | output | W*N | All taps, tap 0 in the least significant word |
| dout | output | W | Shift output, a copy of tap N-1 |

## Verification
The line is first filled from empty with an increasing count. This shows the exact delay of each tap, where each tap sits on the bus, and the moment each tap turns valid. Long runs of random data with random gaps in `en` separate a line that counts accepted words from one that counts clock cycles. Clears land mid-stream: synchronous ones with `en` high and with `en` low, and an asynchronous one between edges. Each clear is followed by a refill, which catches stale memory words leaking onto taps. Flipping `din` between edges shows that the outputs do not pass through the input combinationally.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/tdl_addr_ctrl.sv
module tdl_addr_ctrl
    import tdl_pkg::*;
#(
    parameter int N  = 4,
    parameter int M  = 5,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          sclr,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [N-1:0]  tap_valid
);

    localparam int TOTAL = N * M;
    localparam int CW    = $clog2(TOTAL + 1);

    fill_state_t   state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          accept;

    assign accept = en && !sclr;
    assign wr_en  = accept;
    assign addr   = addr_q;

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_CLEAR;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cnt_d   = cnt_q;
        if (sclr) begin
            state_d = ST_CLEAR;
            addr_d  = '0;
            cnt_d   = '0;
        end else if (en) begin
            addr_d = (addr_q == AW'(M - 1)) ? '0 : addr_q + 1'b1;
            unique case (state_q)
                ST_CLEAR: begin
                    state_d = ST_FILL;
                    cnt_d   = CW'(1);
                end
                ST_FILL: begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CW'(TOTAL - 1)) state_d = ST_FULL;
                end
                ST_FULL: begin
                    cnt_d = cnt_q;
                end
                default: begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs: per-tap valid flags
    always_comb begin
        for (int k = 0; k < N; k++) begin
            unique case (state_q)
                ST_CLEAR: tap_valid[k] = 1'b0;
                ST_FILL:  tap_valid[k] = (cnt_q >= CW'((k + 1) * M));
                ST_FULL:  tap_valid[k] = 1'b1;
                default:  tap_valid[k] = 1'b0;
            endcase
        end
    end

    // R4: no accept, no movement of address or fill count
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (arst)
        (!en && !sclr) |=> ($stable(addr_q) && $stable(cnt_q)));

    // R1: the address wraps after M accepted words
    a_r1_addr_wrap: assert property (@(posedge clk) disable iff (arst)
        (accept && addr_q == AW'(M - 1)) |=> (addr_q == '0));

    // R6: a synchronous clear sends the counter home and empties the line
    a_r6_sclr_home: assert property (@(posedge clk) disable iff (arst)
        sclr |=> (addr_q == '0 && state_q == ST_CLEAR));

    // R7: full is reached only through a partly filled line
    a_r7_full_entry: assert property (@(posedge clk) disable iff (arst)
        (state_q != ST_FULL) |=> (state_q != ST_FULL || $past(state_q) == ST_FILL));

endmodule

// File: rtl/tdl_stage_bank.sv
module tdl_stage_bank #(
    parameter int W  = 8,
    parameter int M  = 5,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [M];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // read the word at the current address before it is replaced
    assign rdata = mem[addr];

    // R1: a written word lands at the address in use when it was written
    a_r1_write_lands: assert property (@(posedge clk) disable iff (arst)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/tdl_ram_tapline.sv
module tdl_ram_tapline #(
    parameter int W = 8,
    parameter int N = 4,
    parameter int M = 5
) (
    input  logic           clk,
    input  logic           arst,
    input  logic           sclr,
    input  logic           en,
    input  logic [W-1:0]   din,
    output logic [W*N-1:0] taps,
    output logic [W-1:0]   dout
);

    localparam int AW = (M > 1) ? $clog2(M) : 1;

    // R3: spacing below 3 is rejected
    if (M < 3) begin : g_r3_bad_spacing
        $error("tdl_ram_tapline: tap spacing M must be at least 3");
    end

    logic [AW-1:0] addr;
    logic          wr_en;
    logic [N-1:0]  tap_valid;
    logic [W-1:0]  stage_rd [N];

    tdl_addr_ctrl #(.N(N), .M(M), .AW(AW)) i_ctrl (
        .clk       (clk),
        .arst      (arst),
        .sclr      (sclr),
        .en        (en),
        .addr      (addr),
        .wr_en     (wr_en),
        .tap_valid (tap_valid)
    );

    for (genvar k = 0; k < N; k++) begin : g_stage
        logic [W-1:0] stage_in;
        if (k == 0) begin : g_head
            assign stage_in = din;
        end else begin : g_link
            assign stage_in = stage_rd[k-1];
        end

        tdl_stage_bank #(.W(W), .M(M), .AW(AW)) i_bank (
            .clk   (clk),
            .arst  (arst),
            .we    (wr_en),
            .addr  (addr),
            .wdata (stage_in),
            .rdata (stage_rd[k])
        );

        assign taps[k*W +: W] = (tap_valid[k] && !arst) ? stage_rd[k] : '0;
    end

    assign dout = taps[(N-1)*W +: W];

    // R4: an edge without accept leaves every tap as it was
    a_r4_taps_hold: assert property (@(posedge clk) disable iff (arst)
        (!en && !sclr) |=> $stable(taps));

    // R6: a synchronous clear zeroes all taps after the edge
    a_r6_sclr_zero: assert property (@(posedge clk) disable iff (arst)
        sclr |=> (taps == '0));

    // R5: outputs are zero whenever the asynchronous clear is held
    always_comb begin
        if (arst) a_r5_arst_zero: assert (taps == '0 && dout == '0);
    end

endmodule

// File: tb/test_tdl_ram_tapline.sv
module test_tdl_ram_tapline;

    localparam int W      = 8;
    localparam int N      = 4;
    localparam int M      = 5;
    localparam int TOT    = N * M;
    localparam int PERIOD = 10;

    logic           clk = 1'b0;
    logic           arst = 1'b1;
    logic           sclr = 1'b0;
    logic           en = 1'b0;
    logic [W-1:0]   din = '0;
    logic [W*N-1:0] taps;
    logic [W-1:0]   dout;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [W-1:0] hist[$];
    int           fill = 0;

    tdl_ram_tapline #(.W(W), .N(N), .M(M)) i_tdl_ram_tapline (
        .clk  (clk),
        .arst (arst),
        .sclr (sclr),
        .en   (en),
        .din  (din),
        .taps (taps),
        .dout (dout)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] exp_tap(input int k);
        int d;
        d = (k + 1) * M;
        if (fill >= d) return hist[d-1];
        return '0;
    endfunction

    task automatic check_all(input string tag);
        for (int k = 0; k < N; k++) begin
            vectors++;
            if (taps[k*W +: W] !== exp_tap(k)) begin
                errors++;
                $display("FAIL %s tap %0d: got %h expected %h at %0t",
                         tag, k, taps[k*W +: W], exp_tap(k), $time);
            end
        end
        vectors++;
        if (dout !== exp_tap(N-1)) begin
            errors++;
            $display("FAIL R2 dout: got %h expected %h at %0t", dout, exp_tap(N-1), $time);
        end
    endtask

    task automatic model_clear();
        hist.delete();
        fill = 0;
    endtask

    // drive inputs, take one edge, update the model, check at the falling edge
    task automatic step(input logic e, input logic s, input logic [W-1:0] d, input string tag);
        en = e; sclr = s; din = d;
        @(posedge clk);
        if (s) model_clear();
        else if (e) begin
            hist.push_front(d);
            if (hist.size() > TOT) void'(hist.pop_back());
            if (fill < TOT) fill++;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        // R5: held asynchronous clear
        #(PERIOD*2 + 1);
        vectors++;
        if (taps !== '0 || dout !== '0) begin
            errors++;
            $display("FAIL R5 under reset: got %h expected 0", taps);
        end
        @(negedge clk);
        arst = 1'b0;
        check_all("R5");

        // R1 R7: fill from empty with a counting pattern
        for (int i = 0; i < TOT + 6; i++) step(1'b1, 1'b0, W'(i + 1), "R1/R7 fill");

        // R4: random gaps in the enable, random data on idle edges too
        for (int i = 0; i < 300; i++)
            step(($urandom % 3) != 0, 1'b0, W'($urandom), "R4 gaps");

        // R6: synchronous clear with enable high, then refill (R7)
        step(1'b1, 1'b1, 8'hA5, "R6 sclr en=1");
        for (int i = 0; i < TOT + 3; i++) step(1'b1, 1'b0, W'($urandom), "R7 refill");

        // R6: synchronous clear with enable low
        step(1'b0, 1'b1, 8'h5A, "R6 sclr en=0");
        for (int i = 0; i < 2*M; i++) step(1'b1, 1'b0, W'($urandom), "R7 refill2");

        // R8: din moves between edges, outputs must not follow
        for (int i = 0; i < 5; i++) begin
            din = ~din;
            #1;
            check_all("R8");
            step(1'b1, 1'b0, W'($urandom), "R8 step");
        end

        // R5: asynchronous clear pulsed between edges
        for (int i = 0; i < TOT; i++) step(1'b1, 1'b0, W'($urandom), "R1 prefill");
        #2 arst = 1'b1;
        #1;
        vectors++;
        if (taps !== '0 || dout !== '0) begin
            errors++;
            $display("FAIL R5 async: got %h expected 0", taps);
        end
        model_clear();
        #1 arst = 1'b0;
        for (int i = 0; i < TOT + 4; i++) step(1'b1, 1'b0, W'($urandom), "R5/R7 after arst");

        // mixed random traffic with occasional clears
        for (int i = 0; i < 500; i++)
            step(($urandom % 4) != 0, ($urandom % 60) == 0, W'($urandom), "R1/R4/R6 mixed");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule